// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A small memory-mapped timer with two or three independent 32-bit channels that count down. Each channel has a reload value, a live counter and a 16-bit control word. One shared byte holds a run bit per channel. A running channel decrements once per prescaled tick of the bus clock; the prescaler has five ratios. When a tick arrives while the counter is at zero, the counter reloads from the channel's reload value. The same tick sets a sticky underflow flag, which drives that channel's interrupt line when the channel has interrupts enabled.

Software sets a channel up while it is halted: it writes the reload value, the counter and the control word, then sets the run bit. It reads the counter to measure elapsed time; all-ones minus the counter rises steadily. It clears the underflow flag by writing the control word with the flag bit at zero. Register reads are combinational on the address and are zero-extended to 32 bits.

Top module: `ctu_top`

## Requirements
- R1: After reset the run byte reads 0, every reload and counter register reads 32'hFFFF_FFFF, every control word reads 0 and all interrupt lines are low.
- R2: The run byte is at address 4 and takes byte writes (size 0). Channel n's registers begin at address 8+12n: reload at +0 and counter at +4, both taking word writes (size 2), and the control word at +8, taking halfword writes (size 1). A write with any other size leaves the register unchanged.
- R3: Bit n of the run byte runs channel n when 1. While the bit is 0, that channel's counter holds its value. Running one channel does not change the counter of another.
- R4: Control bits 2:0 select the tick period as 4, 16, 64, 256 or 1024 bus-clock cycles for codes 0 to 4; codes 5, 6 and 7 give 4. The first decrement lands on the clock edge that is one period after the edge that set the run bit, and later decrements follow every period.
- R5: A tick while the counter is 0 loads the counter from the reload register and sets the underflow flag (control bit 8) on the same edge, so a reload value C gives an underflow every C+1 ticks.
- R6: A control write with bit 8 at 0 clears the underflow flag; a control write with bit 8 at 1 leaves it unchanged.
- R7: Channel n's interrupt output is high exactly while its flag is set and its interrupt enable (control bit 5) is 1.
- R8: A bus write to a counter takes priority over a decrement or reload on the same edge.
- R9: The control word reads back the select code in bits 2:0 as written, the enable in bit 5 and the flag in bit 8, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel underflow interrupt |

## Verification
A bus write lands on the rising edge that samples it, and its effect can be read back on the following falling edge. The first decrement after a run-bit write comes exactly one tick period later, and every later decrement, reload and interrupt change follows at that same period. The bench drives inputs and samples outputs on falling edges. It waits a computed number of falling edges (period minus one, then period, then the full C+1 ticks) before each read. This catches the counter one edge before and one edge after each expected change, for every channel and every select code.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int RUN_ADDR   = 4;
  localparam int GRP_BASE   = 8;
  localparam int GRP_STRIDE = 12;
  localparam int OFS_RELOAD = 0;
  localparam int OFS_COUNT  = 4;
  localparam int OFS_CTRL   = 8;

  localparam int FLAG_BIT = 8;
  localparam int IE_BIT   = 5;

  localparam int PS_W = 10;

  // tick period in clock cycles for a select code; reserved codes fall back to 4
  function automatic logic [10:0] prescale_div(input logic [2:0] sel);
    case (sel)
      3'd1:    return 11'd16;
      3'd2:    return 11'd64;
      3'd3:    return 11'd256;
      3'd4:    return 11'd1024;
      default: return 11'd4;
    endcase
  endfunction

  function automatic int grp_addr(input int ch, input int ofs);
    return GRP_BASE + GRP_STRIDE * ch + ofs;
  endfunction
endpackage

// File: rtl/ctu_prescaler.sv
module ctu_prescaler
  import ctu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] pcount;
  logic [10:0]     div_m1;

  assign div_m1 = prescale_div(sel) - 11'd1;
  assign tick   = run && ({1'b0, pcount} >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcount <= '0;
    else if (!run)   pcount <= '0;
    else if (tick)   pcount <= '0;
    else             pcount <= pcount + 1'b1;
  end

  // a halted channel restarts its prescale phase from zero
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcount == '0);

  // shortest period is four cycles, so ticks never come back to back
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/ctu_channel.sv
module ctu_channel
  import ctu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        reload_we,
  input  logic        count_we,
  input  logic        ctrl_we,
  input  logic [31:0] wdata,
  output logic [31:0] reload_q,
  output logic [31:0] count_q,
  output logic [15:0] ctrl_rd,
  output logic        irq
);
  logic [2:0] sel_q;
  logic       ie_q;
  logic       flag_q;
  logic       tick;
  logic       uf_evt;
  logic       dec_evt;

  ctu_prescaler u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel_q),
    .tick (tick)
  );

  assign uf_evt  = tick && (count_q == '0);
  assign dec_evt = tick && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '1;
    else if (reload_we) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '1;
    else if (count_we) count_q <= wdata;
    else if (uf_evt)   count_q <= reload_q;
    else if (dec_evt)  count_q <= count_q - 32'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        sel_q <= wdata[2:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (uf_evt)       flag_q <= 1'b1;
      else if (ctrl_we) flag_q <= flag_q & wdata[FLAG_BIT];
    end
  end

  assign ctrl_rd = {7'b0, flag_q, 2'b0, ie_q, 2'b0, sel_q};
  assign irq     = flag_q & ie_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_we) |=> $stable(count_q));

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !count_we) |=> count_q == $past(count_q) - 32'd1);

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !count_we && !reload_we) |=> (count_q == $past(reload_q)) && flag_q);

  p_flag_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(uf_evt));

  p_wr_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_we |=> count_q == $past(wdata));
endmodule

// File: rtl/ctu_top.sv
module ctu_top
  import ctu_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam logic [ADDR_W-1:0] RUN_A = ADDR_W'(RUN_ADDR);

  logic [NCH-1:0] run_q;
  logic           run_we;
  logic [31:0]    reload_arr [NCH];
  logic [31:0]    count_arr  [NCH];
  logic [15:0]    ctrl_arr   [NCH];

  assign run_we = bus_we && (bus_size == SZ_BYTE) && (bus_addr == RUN_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_we) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(grp_addr(n, OFS_RELOAD));
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(grp_addr(n, OFS_COUNT));
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(grp_addr(n, OFS_CTRL));
    logic we_reload, we_count, we_ctrl;

    assign we_reload = bus_we && (bus_size == SZ_WORD) && (bus_addr == A_RELOAD);
    assign we_count  = bus_we && (bus_size == SZ_WORD) && (bus_addr == A_COUNT);
    assign we_ctrl   = bus_we && (bus_size == SZ_HALF) && (bus_addr == A_CTRL);

    ctu_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[n]),
      .reload_we(we_reload),
      .count_we (we_count),
      .ctrl_we  (we_ctrl),
      .wdata    (bus_wdata),
      .reload_q (reload_arr[n]),
      .count_q  (count_arr[n]),
      .ctrl_rd  (ctrl_arr[n]),
      .irq      (irq[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == RUN_A) bus_rdata = {{(32-NCH){1'b0}}, run_q};
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(grp_addr(n, OFS_RELOAD))) bus_rdata = reload_arr[n];
      if (bus_addr == ADDR_W'(grp_addr(n, OFS_COUNT)))  bus_rdata = count_arr[n];
      if (bus_addr == ADDR_W'(grp_addr(n, OFS_CTRL)))   bus_rdata = {16'b0, ctrl_arr[n]};
    end
  end

  p_run_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_we |=> run_q == $past(bus_wdata[NCH-1:0]));

  p_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_size != SZ_BYTE) && (bus_addr == RUN_A)) |=> $stable(run_q));
endmodule

// File: tb/ctu_top_test.sv
module ctu_top_test;
  localparam int NCH = 3;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_size = 2'd0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int failures = 0;

  ctu_top #(.NCH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic int a_rel(input int n); return 8 + 12*n; endfunction
  function automatic int a_cnt(input int n); return 12 + 12*n; endfunction
  function automatic int a_ctl(input int n); return 16 + 12*n; endfunction
  function automatic int period(input int sel);
    case (sel)
      1: return 16;
      2: return 64;
      3: return 256;
      4: return 1024;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d);
    bus_addr = AW'(a); bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_fall(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] other_before;
    wait_fall(2);
    rst_n = 1'b1;
    wait_fall(1);

    // R1 reset values
    rd(4, v); chk("R1 run byte", v, 32'h0);
    for (int n = 0; n < NCH; n++) begin
      rd(a_rel(n), v); chk("R1 reload", v, 32'hFFFF_FFFF);
      rd(a_cnt(n), v); chk("R1 counter", v, 32'hFFFF_FFFF);
      rd(a_ctl(n), v); chk("R1 control", v, 32'h0);
    end
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 size-matched writes only
    wr(a_cnt(0), 2'd0, 32'h12); rd(a_cnt(0), v); chk("R2 byte to counter ignored", v, 32'hFFFF_FFFF);
    wr(4, 2'd2, 32'h1);         rd(4, v);        chk("R2 word to run byte ignored", v, 32'h0);
    wr(a_ctl(0), 2'd2, 32'h21); rd(a_ctl(0), v); chk("R2 word to control ignored", v, 32'h0);
    wr(a_rel(1), 2'd1, 32'h7);  rd(a_rel(1), v); chk("R2 half to reload ignored", v, 32'hFFFF_FFFF);
    wr(a_cnt(0), 2'd2, 32'h12); rd(a_cnt(0), v); chk("R2 word to counter", v, 32'h12);

    // sweep every channel and every select code
    for (int ch = 0; ch < NCH; ch++) begin
      for (int sel = 0; sel < 8; sel++) begin
        int d;
        int oth;
        d = period(sel);
        oth = (ch + 1) % NCH;
        wr(4, 2'd0, 32'h0);
        wr(a_rel(ch), 2'd2, 32'd5);
        wr(a_cnt(ch), 2'd2, 32'd2);
        wr(a_ctl(ch), 2'd1, 32'(sel) | 32'h20);
        rd(a_ctl(ch), v); chk("R9 control readback", v, 32'(sel) | 32'h20);
        rd(a_cnt(oth), other_before);
        wr(4, 2'd0, 32'(1 << ch));
        rd(4, v); chk("R3 run byte readback", v, 32'(1 << ch));
        wait_fall(d - 1);
        rd(a_cnt(ch), v); chk("R4 no decrement before period", v, 32'd2);
        wait_fall(1);
        rd(a_cnt(ch), v); chk("R4 first decrement at period", v, 32'd1);
        wait_fall(2*d - 1);
        rd(a_cnt(ch), v); chk("R5 counter at zero", v, 32'd0);
        rd(a_ctl(ch), v); chk("R5 flag clear before underflow", v & 32'h100, 32'h0);
        wait_fall(1);
        rd(a_cnt(ch), v); chk("R5 reload on underflow", v, 32'd5);
        rd(a_ctl(ch), v); chk("R9 control with flag", v, 32'(sel) | 32'h120);
        chk("R7 irq raised", 32'(irq), 32'(1 << ch));
        wait_fall(d);
        rd(a_cnt(ch), v); chk("R5 counting after reload", v, 32'd4);
        wr(4, 2'd0, 32'h0);
        wait_fall(20);
        rd(a_cnt(ch), v); chk("R3 hold while halted", v, 32'd4);
        rd(a_cnt(oth), v); chk("R3 other channel unchanged", v, other_before);
        wr(a_ctl(ch), 2'd1, 32'(sel) | 32'h120);
        rd(a_ctl(ch), v); chk("R6 writing 1 keeps flag", v & 32'h100, 32'h100);
        wr(a_ctl(ch), 2'd1, 32'(sel) | 32'h100);
        chk("R7 irq masked by enable", 32'(irq), 32'h0);
        rd(a_ctl(ch), v); chk("R6 flag kept with enable off", v & 32'h100, 32'h100);
        wr(a_ctl(ch), 2'd1, 32'(sel));
        rd(a_ctl(ch), v); chk("R6 writing 0 clears flag", v & 32'h100, 32'h0);
      end
    end

    // R8 bus write wins over a decrement on the tick edge
    wr(4, 2'd0, 32'h0);
    wr(a_cnt(0), 2'd2, 32'd50);
    wr(a_ctl(0), 2'd1, 32'h0);
    wr(4, 2'd0, 32'h1);
    wait_fall(3);
    wr(a_cnt(0), 2'd2, 32'd100);
    rd(a_cnt(0), v); chk("R8 write beats decrement", v, 32'd100);
    wait_fall(4);
    rd(a_cnt(0), v); chk("R8 decrement resumes", v, 32'd99);
    wr(4, 2'd0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule